// File: doc/BRIEF.md
# Video data-enable generator

This block rebuilds an active-video data-enable from the horizontal and vertical sync pulses of a video stream. A pixel counter restarts on every horizontal sync leading edge and a line counter restarts on every vertical sync leading edge. The generated enable is high only where both counters sit inside a programmed window. The window has a pixel offset, a pixel width, a line offset and a line height. An interlace offset adds a few extra lines to the vertical offset in alternate fields, so one field is longer than the other.

A select input chooses between the generated enable and an incoming enable. The incoming one is passed through with the same latency, so switching the source does not shift the timing. All configuration, the select included, is captured on the vertical sync leading edge. A new setting therefore applies from the next frame, and the window cannot tear in the middle of a frame. A field flag toggles on every frame and is available at the output.

Top module: `vid_de_gen`

## Requirements
- R1: After reset, de_o and field_o are 0, and de_o repeats de_i with a two-cycle delay until the first vertical sync leading edge has been captured.
- R2: With the generator selected, de_o is high only for pixel counts hdly to hdly+wid-1. The pixel count is 0 in the clock where hs_i is first sampled high. de_o reflects each pixel count two clock edges after the inputs of that pixel were sampled.
- R3: With the generator selected, de_o is high only for line counts from the effective vertical delay to that delay plus hgt minus 1. The line count is 0 on the vertical sync leading edge and rises by one on each later horizontal sync leading edge.
- R4: field_o toggles on every vs_i leading edge and holds otherwise. While field_o is 1, the effective vertical delay is vdly plus ilo; while it is 0, it is vdly.
- R5: hdly_i, vdly_i, wid_i, hgt_i, ilo_i and force_gen_i are captured only at a vs_i leading edge. A change at any other time has no effect on de_o before the next such edge.
- R6: When force_gen_i was captured as 0, de_o equals de_i delayed by two clock edges.
- R7: With the generator selected and a width or height of 0 captured, de_o stays 0 for the whole frame.
- R8: The pixel and line counters saturate rather than wrap. A line with no horizontal sync for more than 8192 clocks does not reassert de_o after its window.
- R9: When hs_i and vs_i rise in the same clock, that line counts as line 0.
- R10: Only leading edges count. A sync held high for several clocks restarts its counter once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| de_i | input | 1 | Incoming data enable |
| hdly_i | input | 10 | Pixels from the horizontal sync edge to the first active pixel (reset 260) |
| vdly_i | input | 6 | Lines from the vertical sync edge to the first active line (reset 24) |
| wid_i | input | 12 | Active pixels per line (reset 1280) |
| hgt_i | input | 12 | Active lines per field (reset 720) |
| ilo_i | input | 3 | Extra vertical delay lines applied in field 1 |
| force_gen_i | input | 1 | 1 selects the generated enable, 0 the incoming one |
| de_o | output | 1 | Selected data enable |
| field_o | output | 1 | Current field |

## Verification
The generated enable and the passed-through enable both change two clock edges after the inputs that caused them are sampled. The field flag changes one edge after the vertical sync leading edge. The bench drives all inputs on the falling edge and computes each cycle's expected enable from the pixel and line position it has just driven. It holds that value in a two-stage expected pipeline and the field value in a one-stage one. It compares each against the outputs at the falling edge, so every comparison falls half a cycle clear of the edge that updated the register.

// File: rtl/vid_de_pkg.sv
package vid_de_pkg;
  localparam int HDLY_W   = 10;
  localparam int VDLY_W   = 6;
  localparam int WID_W    = 12;
  localparam int HGT_W    = 12;
  localparam int ILO_W    = 3;
  localparam int HDLY_RST = 260;
  localparam int VDLY_RST = 24;
  localparam int WID_RST  = 1280;
  localparam int HGT_RST  = 720;

  typedef enum logic {
    DE_SRC_EXT = 1'b0,
    DE_SRC_GEN = 1'b1
  } de_src_e;
endpackage

// File: rtl/vde_edge_det.sv
module vde_edge_det #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sig_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_q[g] <= 1'b0;
      else         sig_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
  end
endmodule

// File: rtl/vde_sat_cnt.sv
module vde_sat_cnt #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  // resets saturated so nothing is in window before the first sync edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= MAX;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vde_span_chk.sv
module vde_span_chk #(
  parameter int CW = 13,
  parameter int OW = 10,
  parameter int LW = 12
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [OW-1:0] ofs_i,
  input  logic [LW-1:0] len_i,
  output logic          in_o
);
  localparam int EW = CW + 1;

  logic [EW-1:0] cnt_x, beg_x, end_x;

  assign cnt_x = EW'(cnt_i);
  assign beg_x = EW'(ofs_i);
  assign end_x = beg_x + EW'(len_i);
  assign in_o  = (cnt_x >= beg_x) && (cnt_x < end_x);
endmodule

// File: rtl/vde_cfg_shadow.sv
module vde_cfg_shadow
  import vid_de_pkg::*;
#(
  parameter int HDLY_W   = vid_de_pkg::HDLY_W,
  parameter int VDLY_W   = vid_de_pkg::VDLY_W,
  parameter int WID_W    = vid_de_pkg::WID_W,
  parameter int HGT_W    = vid_de_pkg::HGT_W,
  parameter int ILO_W    = vid_de_pkg::ILO_W,
  parameter int HDLY_RST = vid_de_pkg::HDLY_RST,
  parameter int VDLY_RST = vid_de_pkg::VDLY_RST,
  parameter int WID_RST  = vid_de_pkg::WID_RST,
  parameter int HGT_RST  = vid_de_pkg::HGT_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HDLY_W-1:0] hdly_i,
  input  logic [VDLY_W-1:0] vdly_i,
  input  logic [WID_W-1:0]  wid_i,
  input  logic [HGT_W-1:0]  hgt_i,
  input  logic [ILO_W-1:0]  ilo_i,
  input  logic              force_gen_i,
  output logic [HDLY_W-1:0] hdly_o,
  output logic [VDLY_W-1:0] vdly_o,
  output logic [WID_W-1:0]  wid_o,
  output logic [HGT_W-1:0]  hgt_o,
  output logic [ILO_W-1:0]  ilo_o,
  output de_src_e           src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdly_o <= HDLY_W'(HDLY_RST);
      vdly_o <= VDLY_W'(VDLY_RST);
      wid_o  <= WID_W'(WID_RST);
      hgt_o  <= HGT_W'(HGT_RST);
      ilo_o  <= '0;
      src_o  <= DE_SRC_EXT;
    end else if (load_i) begin
      hdly_o <= hdly_i;
      vdly_o <= vdly_i;
      wid_o  <= wid_i;
      hgt_o  <= hgt_i;
      ilo_o  <= ilo_i;
      src_o  <= force_gen_i ? DE_SRC_GEN : DE_SRC_EXT;
    end
  end
endmodule

// File: rtl/vid_de_gen.sv
module vid_de_gen
  import vid_de_pkg::*;
#(
  parameter int HDLY_W   = vid_de_pkg::HDLY_W,
  parameter int VDLY_W   = vid_de_pkg::VDLY_W,
  parameter int WID_W    = vid_de_pkg::WID_W,
  parameter int HGT_W    = vid_de_pkg::HGT_W,
  parameter int ILO_W    = vid_de_pkg::ILO_W,
  parameter int HDLY_RST = vid_de_pkg::HDLY_RST,
  parameter int VDLY_RST = vid_de_pkg::VDLY_RST,
  parameter int WID_RST  = vid_de_pkg::WID_RST,
  parameter int HGT_RST  = vid_de_pkg::HGT_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic              de_i,
  input  logic [HDLY_W-1:0] hdly_i,
  input  logic [VDLY_W-1:0] vdly_i,
  input  logic [WID_W-1:0]  wid_i,
  input  logic [HGT_W-1:0]  hgt_i,
  input  logic [ILO_W-1:0]  ilo_i,
  input  logic              force_gen_i,
  output logic              de_o,
  output logic              field_o
);
  localparam int VE_W   = ((VDLY_W > ILO_W) ? VDLY_W : ILO_W) + 1;
  localparam int PIX_W  = ((HDLY_W > WID_W) ? HDLY_W : WID_W) + 1;
  localparam int LINE_W = ((VE_W > HGT_W) ? VE_W : HGT_W) + 1;

  logic [1:0]        sync_rise;
  logic              hs_rise, vs_rise;
  logic [HDLY_W-1:0] hdly_q;
  logic [VDLY_W-1:0] vdly_q;
  logic [WID_W-1:0]  wid_q;
  logic [HGT_W-1:0]  hgt_q;
  logic [ILO_W-1:0]  ilo_q;
  de_src_e           src_q;
  logic              src_gen;
  logic              field_q;
  logic [VE_W-1:0]   vdly_eff;
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              h_in, v_in, de_gen;
  logic              de_i_q, de_q;

  vde_edge_det #(.N(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({vs_i, hs_i}),
    .rise_o(sync_rise)
  );
  assign hs_rise = sync_rise[0];
  assign vs_rise = sync_rise[1];

  vde_cfg_shadow #(
    .HDLY_W(HDLY_W), .VDLY_W(VDLY_W), .WID_W(WID_W), .HGT_W(HGT_W), .ILO_W(ILO_W),
    .HDLY_RST(HDLY_RST), .VDLY_RST(VDLY_RST), .WID_RST(WID_RST), .HGT_RST(HGT_RST)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (vs_rise),
    .hdly_i     (hdly_i),
    .vdly_i     (vdly_i),
    .wid_i      (wid_i),
    .hgt_i      (hgt_i),
    .ilo_i      (ilo_i),
    .force_gen_i(force_gen_i),
    .hdly_o     (hdly_q),
    .vdly_o     (vdly_q),
    .wid_o      (wid_q),
    .hgt_o      (hgt_q),
    .ilo_o      (ilo_q),
    .src_o      (src_q)
  );
  assign src_gen = (src_q == DE_SRC_GEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      field_q <= 1'b0;
    else if (vs_rise) field_q <= ~field_q;
  end

  // field 1 is lengthened by the interlace offset
  assign vdly_eff = VE_W'(vdly_q) + (field_q ? VE_W'(ilo_q) : '0);

  vde_sat_cnt #(.W(PIX_W)) u_pix_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (hs_rise),
    .inc_i (1'b1),
    .cnt_o (pix_cnt)
  );

  // vertical edge wins over a coincident horizontal edge
  vde_sat_cnt #(.W(LINE_W)) u_line_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (vs_rise),
    .inc_i (hs_rise),
    .cnt_o (line_cnt)
  );

  vde_span_chk #(.CW(PIX_W), .OW(HDLY_W), .LW(WID_W)) u_h_span (
    .cnt_i(pix_cnt),
    .ofs_i(hdly_q),
    .len_i(wid_q),
    .in_o (h_in)
  );

  vde_span_chk #(.CW(LINE_W), .OW(VE_W), .LW(HGT_W)) u_v_span (
    .cnt_i(line_cnt),
    .ofs_i(vdly_eff),
    .len_i(hgt_q),
    .in_o (v_in)
  );

  assign de_gen = h_in & v_in;

  // incoming DE is delayed one stage to line up with the counter stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_i_q <= 1'b0;
      de_q   <= 1'b0;
    end else begin
      de_i_q <= de_i;
      de_q   <= src_gen ? de_gen : de_i_q;
    end
  end

  assign de_o    = de_q;
  assign field_o = field_q;
endmodule

// File: rtl/vid_de_gen_chk.sv
module vid_de_gen_chk #(
  parameter int PIX_W  = 13,
  parameter int LINE_W = 13,
  parameter int WID_W  = 12,
  parameter int HGT_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hs_rise,
  input logic              vs_rise,
  input logic              src_gen,
  input logic              de_i_q,
  input logic              de_o,
  input logic              field_o,
  input logic [WID_W-1:0]  wid_q,
  input logic [HGT_W-1:0]  hgt_q,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt
);
  AST_FIELD_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise |=> field_o != $past(field_o)); // R4
  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_rise |=> $stable(field_o)); // R4
  AST_PIX_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_rise |=> pix_cnt == '0); // R2
  AST_LINE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise |=> line_cnt == '0); // R9
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_rise |=> $stable(wid_q) && $stable(hgt_q)); // R5
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_gen |=> de_o == $past(de_i_q)); // R6
  AST_ZERO_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_gen && (wid_q == '0 || hgt_q == '0)) |=> !de_o); // R7
  AST_PIX_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&pix_cnt) && !hs_rise) |=> (&pix_cnt)); // R8
  AST_LINE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&line_cnt) && !vs_rise) |=> (&line_cnt)); // R8
  AST_EDGE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_rise |=> !hs_rise); // R10
endmodule

bind vid_de_gen vid_de_gen_chk #(
  .PIX_W(PIX_W), .LINE_W(LINE_W), .WID_W(WID_W), .HGT_W(HGT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hs_rise (hs_rise),
  .vs_rise (vs_rise),
  .src_gen (src_gen),
  .de_i_q  (de_i_q),
  .de_o    (de_o),
  .field_o (field_o),
  .wid_q   (wid_q),
  .hgt_q   (hgt_q),
  .pix_cnt (pix_cnt),
  .line_cnt(line_cnt)
);

// File: tb/vid_de_gen_tb.sv
module vid_de_gen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
  logic [9:0]  hdly_i = '0;
  logic [5:0]  vdly_i = '0;
  logic [11:0] wid_i = '0, hgt_i = '0;
  logic [2:0]  ilo_i = '0;
  logic        force_gen_i = 1'b0;
  logic        de_o, field_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit fld_m = 1'b0;
  logic ed1 = 1'b0, ed2 = 1'b0, ef1 = 1'b0;
  string tag1 = "R1", tag2 = "R1";

  always #4 clk = ~clk;

  vid_de_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i),
    .hdly_i(hdly_i), .vdly_i(vdly_i), .wid_i(wid_i), .hgt_i(hgt_i),
    .ilo_i(ilo_i), .force_gen_i(force_gen_i), .de_o(de_o), .field_o(field_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: check outputs due now, then drive this cycle's inputs
  task automatic step(input logic hs, input logic vs, input logic dei,
                      input logic exp_de, input logic exp_fld, input string tag);
    @(negedge clk);
    chk(de_o, ed2, tag2, "de_o");          // due two edges after its inputs
    chk(field_o, ef1, "R4", "field_o");    // due one edge after vsync
    hs_i = hs; vs_i = vs; de_i = dei;
    ed2 = ed1; tag2 = tag1;
    ed1 = exp_de; tag1 = tag; ef1 = exp_fld;
  endtask

  task automatic set_cfg(input int hd, input int vd, input int w, input int h,
                         input int ilo, input bit frc);
    hdly_i = 10'(hd); vdly_i = 6'(vd); wid_i = 12'(w); hgt_i = 12'(h);
    ilo_i = 3'(ilo); force_gen_i = frc;
  endtask

  // frame starts with hs and vs rising together (R9); hs 2 clocks wide, vs a whole line (R10)
  task automatic run_frame(input int nl, input int ll, input int long_line,
                           input int hd, input int vd, input int w, input int h,
                           input int ilo, input bit frc, input string tag);
    int ve;
    fld_m = ~fld_m;
    ve = vd + (fld_m ? ilo : 0);
    for (int l = 0; l < nl; l++) begin
      int len;
      len = (l == long_line) ? 9000 : ll;
      for (int p = 0; p < len; p++) begin
        logic gen, dei;
        gen = (l >= ve) && (l < ve + h) && (p >= hd) && (p < hd + w);
        dei = ((p + 2 * l) % 3) == 0;
        @(negedge clk);
        #0;
        if (l == 0 && p == 0) set_cfg(hd, vd, w, h, ilo, frc);
        // R5: junk settings mid-frame must not reach this frame
        if (l == 1 && p == 0) set_cfg(0, 0, w + 5, h + 5, 0, !frc);
        step_nowait(p < 2, l == 0, dei, frc ? gen : dei, fld_m, tag);
      end
    end
  endtask

  task automatic step_nowait(input logic hs, input logic vs, input logic dei,
                             input logic exp_de, input logic exp_fld, input string tag);
    chk(de_o, ed2, tag2, "de_o");
    chk(field_o, ef1, "R4", "field_o");
    hs_i = hs; vs_i = vs; de_i = dei;
    ed2 = ed1; tag2 = tag1;
    ed1 = exp_de; tag1 = tag; ef1 = exp_fld;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(de_o, 1'b0, "R1", "de_o reset");
    chk(field_o, 1'b0, "R1", "field_o reset");
    rst_ni = 1'b1;
    // R1: passthrough before first vsync edge, generator settings ignored
    set_cfg(0, 0, 8, 8, 0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'(i % 4 == 1 || i % 7 == 0), 1'(i % 4 == 1 || i % 7 == 0), 1'b0, "R1");
    // R2 R3 R4 R5 R7 R9 R10: sweep of small windows over both fields
    for (int hd = 0; hd <= 3; hd += 3)
      for (int vd = 0; vd <= 2; vd += 2)
        for (int w = 0; w <= 4; w += (w == 0) ? 1 : 3)
          for (int h = 0; h <= 3; h += 3)
            for (int ilo = 0; ilo <= 3; ilo += 3)
              for (int f = 0; f < 2; f++) begin
                string tg;
                tg = (w == 0 || h == 0) ? "R7" : (ilo != 0) ? "R4/R3" : "R2/R3/R5/R9/R10";
                run_frame(10, 12, -1, hd, vd, w, h, ilo, 1'b1, tg);
              end
    // R6: incoming DE selected
    run_frame(6, 12, -1, 1, 1, 3, 2, 0, 1'b0, "R6");
    run_frame(6, 12, -1, 1, 1, 3, 2, 0, 1'b0, "R6");
    // R5: force captured back on at frame edge only
    run_frame(6, 12, -1, 2, 1, 5, 3, 1, 1'b1, "R5");
    // R8: a line with no hsync for 9000 clocks must not re-open the window
    run_frame(5, 12, 1, 2, 1, 4, 3, 0, 1'b1, "R8");
    run_frame(5, 12, 2, 2, 0, 4, 3, 0, 1'b1, "R8");
    // flush
    run_frame(3, 12, -1, 0, 0, 0, 0, 0, 1'b1, "R7");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule